// File: doc/BRIEF.md
# Hybrid Iterative-Plus-Tree Maximum Finder

This block finds the largest of sixteen unsigned bytes presented together as one 128-bit vector. A single-cycle start strobe captures the vector. The inputs fall into four groups of four adjacent elements. Each group has one comparator and one load-enabled register that walk through the group's members, one per cycle. A registered two-level tree of three compare-and-select nodes then reduces the four group winners to one value and its element index.

The result appears with a one-cycle valid pulse five cycles after start is sampled. This sits between a single accumulator, which needs sixteen cycles, and a full sixteen-input tree, which needs fifteen wide comparators. A start that arrives while a computation is running is dropped. The block takes a new start again in the cycle its valid pulse is high.

Top module: `hybrid_max_finder`

## Requirements
- R1: After reset `valid_o` is low, and it stays low until a start has been accepted.
- R2: A start accepted at clock edge E raises `valid_o` during the cycle that follows edge E+5, that is, five cycles later. No valid pulse appears before that cycle.
- R3: When `valid_o` is high, `max_o` equals the largest of the sixteen captured elements, compared as unsigned 8-bit numbers.
- R4: When `valid_o` is high, `idx_o` gives the position j of an element equal to `max_o`. Element j occupies `data_i[8*j+7 : 8*j]`.
- R5: When several elements share the maximum value, `idx_o` reports the lowest such position.
- R6: A start that arrives while a computation is in progress is ignored. It produces no extra valid pulse and does not change the result.
- R7: `data_i` is sampled only at the edge that accepts a start. Later changes on `data_i` do not affect the result.
- R8: `valid_o` is high for exactly one cycle per accepted start.
- R9: A start presented in the same cycle that `valid_o` is high is accepted. Its result follows five cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; captures `data_i` when the block is idle |
| data_i | input | 128 | Sixteen unsigned bytes; element j in bits 8j+7..8j |
| valid_o | output | 1 | One-cycle pulse marking a valid result |
| max_o | output | 8 | Largest element |
| idx_o | output | 4 | Position of the largest element (lowest on ties) |

## Verification
The sweep places a maximum at every position paired with a tie at every other position. A design that let a later equal element overwrite the running maximum, or that preferred the right-hand child in the tree, would report the higher index. Single maxima at each of the sixteen positions expose a wrong element select in a group or a swapped tree branch, which would show up as a wrong index or value. The bench also fires start pulses with different data during the busy window, and scrambles `data_i` after capture. A block that restarted, or read data live, would emit an early or second pulse or return the wrong vector's maximum. Back-to-back starts timed on the valid cycle catch a busy flag that clears one cycle late, because the second vector would then be lost.

// File: rtl/hmax_pkg.sv
package hmax_pkg;
  localparam int unsigned HMAX_DATA_W     = 8;
  localparam int unsigned HMAX_GROUPS     = 4;
  localparam int unsigned HMAX_GROUP_SIZE = 4;
endpackage

// File: rtl/hmax_group_acc.sv
module hmax_group_acc #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] elem_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] max_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [DATA_W-1:0] max_q;
  logic [IDX_W-1:0]  idx_q;

  // strict compare keeps the earlier element on ties
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q <= '0;
      idx_q <= '0;
    end else if (en_i && (first_i || elem_i > max_q)) begin
      max_q <= elem_i;
      idx_q <= idx_i;
    end
  end

  assign max_o = max_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/hmax_cmp_node.sv
module hmax_cmp_node #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_val_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  input  logic [DATA_W-1:0] b_val_i,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic [DATA_W-1:0] val_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [DATA_W-1:0] val_q;
  logic [IDX_W-1:0]  idx_q;

  // a carries the lower indices; b wins only when strictly larger
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      idx_q <= '0;
    end else if (b_val_i > a_val_i) begin
      val_q <= b_val_i;
      idx_q <= b_idx_i;
    end else begin
      val_q <= a_val_i;
      idx_q <= a_idx_i;
    end
  end

  assign val_o = val_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/hybrid_max_finder.sv
module hybrid_max_finder #(
  parameter int unsigned DATA_W     = hmax_pkg::HMAX_DATA_W,
  parameter int unsigned GROUPS     = hmax_pkg::HMAX_GROUPS,
  parameter int unsigned GROUP_SIZE = hmax_pkg::HMAX_GROUP_SIZE,
  localparam int unsigned N         = GROUPS * GROUP_SIZE,
  localparam int unsigned IDX_W     = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [N*DATA_W-1:0] data_i,
  output logic                valid_o,
  output logic [DATA_W-1:0]   max_o,
  output logic [IDX_W-1:0]    idx_o
);
  localparam int unsigned LEVELS = $clog2(GROUPS);
  localparam int unsigned STEP_W = $clog2(GROUP_SIZE);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(GROUP_SIZE - 1);

  logic                busy_q;
  logic                scan_q;
  logic [STEP_W-1:0]   step_q;
  logic [N*DATA_W-1:0] data_q;
  logic [LEVELS:0]     vpipe_q;
  logic                accept;
  logic                scan_last;

  assign accept    = start_i && !busy_q;
  assign scan_last = scan_q && (step_q == LAST_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      scan_q  <= 1'b0;
      step_q  <= '0;
      data_q  <= '0;
      vpipe_q <= '0;
    end else begin
      vpipe_q <= {vpipe_q[LEVELS-1:0], scan_last};
      if (accept) begin
        busy_q <= 1'b1;
        scan_q <= 1'b1;
        step_q <= STEP_W'(1);
        data_q <= data_i;
      end else begin
        if (vpipe_q[LEVELS-1]) busy_q <= 1'b0;
        if (scan_last) begin
          scan_q <= 1'b0;
          step_q <= '0;
        end else if (scan_q) begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  logic [DATA_W-1:0] grp_val [GROUPS];
  logic [IDX_W-1:0]  grp_idx [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [STEP_W-1:0] pos;
    logic [IDX_W-1:0]  eidx;
    logic [DATA_W-1:0] elem;

    // element 0 comes straight from the port on the accept edge
    always_comb begin
      pos  = scan_q ? step_q : '0;
      eidx = IDX_W'(g * GROUP_SIZE) + IDX_W'(pos);
      elem = scan_q ? data_q[int'(eidx)*DATA_W +: DATA_W]
                    : data_i[int'(eidx)*DATA_W +: DATA_W];
    end

    hmax_group_acc #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (accept || scan_q),
      .first_i (accept),
      .elem_i  (elem),
      .idx_i   (eidx),
      .max_o   (grp_val[g]),
      .idx_o   (grp_idx[g])
    );
  end

  // heap-numbered tree: node k reduces children 2k and 2k+1, root is node 1
  logic [DATA_W-1:0] node_val [1:GROUPS-1];
  logic [IDX_W-1:0]  node_idx [1:GROUPS-1];

  for (genvar k = 1; k < GROUPS; k++) begin : g_node
    logic [DATA_W-1:0] a_val, b_val;
    logic [IDX_W-1:0]  a_idx, b_idx;
    if (2 * k >= GROUPS) begin : g_leaf
      assign a_val = grp_val[2*k-GROUPS];
      assign a_idx = grp_idx[2*k-GROUPS];
      assign b_val = grp_val[2*k+1-GROUPS];
      assign b_idx = grp_idx[2*k+1-GROUPS];
    end else begin : g_inner
      assign a_val = node_val[2*k];
      assign a_idx = node_idx[2*k];
      assign b_val = node_val[2*k+1];
      assign b_idx = node_idx[2*k+1];
    end
    hmax_cmp_node #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_node (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .a_val_i (a_val),
      .a_idx_i (a_idx),
      .b_val_i (b_val),
      .b_idx_i (b_idx),
      .val_o   (node_val[k]),
      .idx_o   (node_idx[k])
    );
  end

  assign valid_o = vpipe_q[LEVELS];
  assign max_o   = node_val[1];
  assign idx_o   = node_idx[1];
endmodule

// File: rtl/hmax_checker.sv
module hmax_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N      = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned LAT    = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [N*DATA_W-1:0] data_i,
  input logic                busy_i,
  input logic [N*DATA_W-1:0] held_i,
  input logic                valid_o,
  input logic [DATA_W-1:0]   max_o,
  input logic [IDX_W-1:0]    idx_o
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [N*DATA_W-1:0] cap_q;
  logic [CW-1:0]       cnt_q;
  logic                greater, tie_lower;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      cnt_q <= '0;
    end else if (start_i && !busy_i) begin
      cap_q <= data_i;
      cnt_q <= CW'(1);
    end else if (cnt_q == CW'(LAT)) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_comb begin
    greater   = 1'b0;
    tie_lower = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (cap_q[j*DATA_W +: DATA_W] > max_o) greater = 1'b1;
      if (cap_q[j*DATA_W +: DATA_W] == max_o && IDX_W'(j) < idx_o) tie_lower = 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) (cnt_q == '0) |-> !valid_o); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |-> (cnt_q == CW'(LAT))); // R2
  AST_MAX_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |-> !greater); // R3
  AST_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |-> (cap_q[int'(idx_o)*DATA_W +: DATA_W] == max_o)); // R4
  AST_TIE_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |-> !tie_lower); // R5
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni) (start_i && busy_i) |=> $stable(held_i)); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |=> !valid_o); // R8
endmodule

bind hybrid_max_finder hmax_checker #(
  .DATA_W (DATA_W),
  .N      (N),
  .IDX_W  (IDX_W),
  .LAT    (GROUP_SIZE + $clog2(GROUPS))
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .data_i  (data_i),
  .busy_i  (busy_q),
  .held_i  (data_q),
  .valid_o (valid_o),
  .max_o   (max_o),
  .idx_o   (idx_o)
);

// File: tb/sim_hybrid_max_finder.sv
module sim_hybrid_max_finder;
  localparam int N  = 16;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [127:0]  data_i = '0;
  logic          valid_o;
  logic [7:0]    max_o;
  logic [3:0]    idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  hybrid_max_finder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .data_i(data_i),
    .valid_o(valid_o), .max_o(max_o), .idx_o(idx_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rand_vec();
    logic [127:0] v;
    for (int j = 0; j < N; j++) v[j*DW +: DW] = 8'($urandom);
    return v;
  endfunction

  // entered one negedge after the start edge, with start already low
  task automatic watch(input logic [127:0] v, input bit intrude, input bit chain,
                       input logic [127:0] w, input string tag);
    int best = -1;
    int bidx = 0;
    for (int j = 0; j < N; j++)
      if (int'(v[j*DW +: DW]) > best) begin
        best = int'(v[j*DW +: DW]);
        bidx = j;
      end
    chk(valid_o == 1'b0, "R2 early", int'(valid_o), 0);
    for (int k = 2; k <= 6; k++) begin
      @(negedge clk_i);
      chk(valid_o == (k == 6), (intrude ? "R6 pulse" : "R2 timing"), int'(valid_o), int'(k == 6));
      if (intrude && k <= 4) begin
        start_i = 1'b1;
        data_i  = rand_vec();
      end else if (k == 5) begin
        start_i = 1'b0;
      end
      if (k == 6) begin
        chk(max_o == 8'(best), {tag, " R3 max"}, int'(max_o), best);
        chk(idx_o == 4'(bidx), {tag, " R4 R5 idx"}, int'(idx_o), bidx);
        if (chain) begin
          start_i = 1'b1;
          data_i  = w;
        end
      end
    end
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R8 pulse width", int'(valid_o), 0);
    if (chain) begin
      start_i = 1'b0;
      data_i  = ~w;
      watch(w, 1'b0, 1'b0, '0, "R9 chained");
    end
  endtask

  task automatic run(input logic [127:0] v, input bit intrude, input bit chain,
                     input logic [127:0] w, input string tag);
    @(negedge clk_i);
    start_i = 1'b1;
    data_i  = v;
    @(negedge clk_i);
    start_i = 1'b0;
    data_i  = ~v; // R7: scrambled after capture
    watch(v, intrude, chain, w, tag);
  endtask

  initial begin
    logic [127:0] v;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R1 reset valid", int'(valid_o), 0);
    rst_ni = 1'b1;
    repeat (6) begin
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R1 idle valid", int'(valid_o), 0);
    end

    run('0, 0, 0, '0, "zeros R5");
    run({128{1'b1}}, 0, 0, '0, "ones R5");
    for (int j = 0; j < N; j++) v[j*DW +: DW] = 8'(j * 7 + 1);
    run(v, 0, 0, '0, "ascending");
    for (int j = 0; j < N; j++) v[j*DW +: DW] = 8'(250 - j * 9);
    run(v, 0, 0, '0, "descending");

    // single maximum at every position (R4)
    for (int p = 0; p < N; p++) begin
      v = '0;
      for (int j = 0; j < N; j++) v[j*DW +: DW] = 8'($urandom_range(0, 254));
      v[p*DW +: DW] = 8'hFF;
      run(v, 0, 0, '0, "single max");
    end

    // every ordered pair of tied maxima (R5)
    for (int p = 0; p < N; p++)
      for (int q = 0; q < N; q++) begin
        for (int j = 0; j < N; j++) v[j*DW +: DW] = 8'($urandom_range(0, 199));
        v[p*DW +: DW] = 8'd200;
        v[q*DW +: DW] = 8'd200;
        run(v, 0, 0, '0, "tie pair R5");
      end

    repeat (100) run(rand_vec(), 0, 0, '0, "random");
    repeat (20)  run(rand_vec(), 1, 0, '0, "intruded R6");
    repeat (20)  run(rand_vec(), 0, 1, rand_vec(), "chain R9");

    // no spurious pulse after an ignored start
    repeat (8) begin
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R6 quiet", int'(valid_o), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule